// File: doc/BRIEF.md
# Fetch Source Predictor

This block decides, once per fetch, which of three instruction sources the front end should read next: the line buffer, the decoded-instruction cache, or the instruction cache. The aim is to use the cheapest source that is likely to hit. When the decoded cache is likely to miss, the block sends the fetch straight to the instruction cache, so that the fetch does not pay for a miss and then a second access.

The decision uses two kinds of information. If the next fetch stays in the same cache line as the current one, the block uses line locality: the line buffer or the decoded cache keeps serving the fetch if it is the current source and can still hit. If the next fetch leaves the line, the block consults a small direct-mapped table that holds, for each current line, the tag that execution went to the last time it left that line. A stored tag equal to the current fetch tag means the next line is expected in the decoded cache.

The fetch unit supplies the source it actually used for the current fetch. Resolved line-crossing fetches train the table one cycle after they occur. The cache arrays and branch prediction are outside this block.

Top module: `fetch_src_pred`

## Requirements
- R1: While reset is low and after it is released, every table entry is invalid. A line-crossing lookup before any training therefore yields the instruction cache, and a reset in the middle of a run discards all training.
- R2: The source code on `next_src` and `cur_src` is 2'b00 for the line buffer, 2'b01 for the decoded cache and 2'b10 for the instruction cache. `next_src` never shows 2'b11.
- R3: Two addresses are in the same line when they agree in every bit above the low LINE_OFF_W bits (16-byte lines by default). For a same-line next fetch with `cur_src` = line buffer, `next_src` is the line buffer.
- R4: For a same-line next fetch with `cur_src` = decoded cache and `next_dc_valid` high, `next_src` is the decoded cache.
- R5: For every other same-line case, `next_src` is the instruction cache. This covers `cur_src` = instruction cache, and `cur_src` = decoded cache with `next_dc_valid` low.
- R6: For a line-crossing next fetch, `next_src` is the decoded cache when both of these hold: the table entry at index cur_addr[LINE_OFF_W+IDX_W-1:LINE_OFF_W] is valid, and its stored tag equals cur_addr[ADDR_W-1:TAG_LSB] (bits 31:9 by default).
- R7: For a line-crossing next fetch, `next_src` is the instruction cache when the indexed entry is invalid or its stored tag differs from the current tag.
- R8: A line-crossing fetch with `fetch_valid` high writes valid plus next_addr[ADDR_W-1:TAG_LSB] into the entry indexed by `cur_addr`. The write takes effect on the second rising edge after the fetch cycle. A lookup in the cycle right after the fetch still sees the old entry, and a later write overwrites the entry.
- R9: `next_src` is a combinational function of the inputs and the table state in the same cycle.
- R10: With `fetch_valid` low, no table entry changes, whatever addresses are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to clk |
| fetch_valid | input | 1 | A fetch resolves this cycle; enables table training |
| cur_addr | input | ADDR_W | Address of the current fetch |
| next_addr | input | ADDR_W | Address of the next fetch |
| cur_src | input | 2 | Source that served the current fetch |
| next_dc_valid | input | 1 | The next instruction is valid in the decoded cache |
| next_src | output | 2 | Chosen source for the next fetch |

## Verification
A corrupted or stale table entry can only show on `next_src` during a line-crossing lookup that uses the affected index. It then appears as a choice of decoded cache where the instruction cache was expected, or the reverse, in the same cycle as the lookup. The bench therefore trains entries and reads them back through crossing lookups. It probes the cycle just after training and the cycles after that, to pin down the one-cycle write lag. It also aliases two tags onto one index and reuses an index after reset. Same-line decisions hold no state, so any fault there shows at once for the specific `cur_src` and valid combination that triggers it.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic [1:0] {
    SRC_LB = 2'b00,
    SRC_DC = 2'b01,
    SRC_IC = 2'b10
  } fsp_src_e;
endpackage

// File: rtl/fsp_line_table.sv
// Direct-mapped table of predicted next-line tags with a one-cycle
// delayed write port.
module fsp_line_table #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [TAG_W-1:0] upd_tag,
  output logic             wr_pend
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic               pend_q;
  logic [IDX_W-1:0]   widx_q;
  logic [TAG_W-1:0]   wtag_q;
  logic [ENTRIES-1:0] wsel;

  // one-hot write select, one bit per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_sel
    assign wsel[g] = pend_q && (widx_q == IDX_W'(g));
  end

  always_comb begin
    valid_d = valid_q | wsel;
  end

  // pending write stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= upd_en;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      widx_q <= upd_idx;
      wtag_q <= upd_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (pend_q) begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pend_q) begin
      tag_q[widx_q] <= wtag_q;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign wr_pend  = pend_q;

  // R8: a training request is staged for exactly one cycle
  p_pend_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> wr_pend);
  // R10: no request, no write in the next cycle
  p_idle_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> !wr_pend);
  // R10: valid bits only change while a write is pending
  p_valid_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pend |=> $stable(valid_q));
endmodule

// File: rtl/fsp_select.sv
// Combinational choice of the next fetch source.
module fsp_select #(
  parameter int TAG_W = 23
) (
  input  logic             same_line,
  input  logic [1:0]       cur_src,
  input  logic             next_dc_valid,
  input  logic             pred_valid,
  input  logic [TAG_W-1:0] pred_tag,
  input  logic [TAG_W-1:0] cur_tag,
  output logic [1:0]       next_src
);
  import fsp_pkg::*;

  fsp_src_e choice;

  always_comb begin
    choice = SRC_IC;
    if (same_line) begin
      if (cur_src == SRC_LB)
        choice = SRC_LB;
      else if (cur_src == SRC_DC && next_dc_valid)
        choice = SRC_DC;
    end else if (pred_valid && (pred_tag == cur_tag)) begin
      choice = SRC_DC;
    end
  end

  assign next_src = choice;
endmodule

// File: rtl/fetch_src_pred.sv
module fetch_src_pred #(
  parameter int ADDR_W     = 32,
  parameter int LINE_OFF_W = 4,
  parameter int IDX_W      = 6,
  parameter int TAG_LSB    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] next_addr,
  input  logic [1:0]        cur_src,
  input  logic              next_dc_valid,
  output logic [1:0]        next_src
);
  import fsp_pkg::*;

  localparam int TAG_W = ADDR_W - TAG_LSB;

  logic [ADDR_W-1:0] cur_line, nxt_line;
  logic              same_line;
  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag, nxt_tag, pred_tag;
  logic              pred_valid, upd_en, wr_pend;

  assign cur_line  = cur_addr >> LINE_OFF_W;
  assign nxt_line  = next_addr >> LINE_OFF_W;
  assign same_line = (cur_line == nxt_line);
  assign cur_idx   = cur_line[IDX_W-1:0];
  assign cur_tag   = TAG_W'(cur_addr >> TAG_LSB);
  assign nxt_tag   = TAG_W'(next_addr >> TAG_LSB);
  assign upd_en    = fetch_valid && !same_line;

  fsp_line_table #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (cur_idx),
    .rd_valid (pred_valid),
    .rd_tag   (pred_tag),
    .upd_en   (upd_en),
    .upd_idx  (cur_idx),
    .upd_tag  (nxt_tag),
    .wr_pend  (wr_pend)
  );

  fsp_select #(.TAG_W(TAG_W)) u_select (
    .same_line     (same_line),
    .cur_src       (cur_src),
    .next_dc_valid (next_dc_valid),
    .pred_valid    (pred_valid),
    .pred_tag      (pred_tag),
    .cur_tag       (cur_tag),
    .next_src      (next_src)
  );

  p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    next_src != 2'b11);
  p_lb_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (same_line && cur_src == SRC_LB) |-> next_src == SRC_LB);
  p_dc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (same_line && cur_src == SRC_DC && next_dc_valid) |-> next_src == SRC_DC);
  p_same_ic_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (same_line && cur_src == SRC_IC) |-> next_src == SRC_IC);
  p_cross_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!same_line && !pred_valid) |-> next_src == SRC_IC);
  p_cross_train_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !same_line) |=> wr_pend);
endmodule

// File: tb/tb_fetch_src_pred.sv
module tb_fetch_src_pred;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid;
  logic [31:0] cur_addr, next_addr;
  logic [1:0]  cur_src;
  logic        next_dc_valid;
  logic [1:0]  next_src;

  int checks = 0;
  int errors = 0;

  localparam logic [1:0] LB = 2'b00, DC = 2'b01, IC = 2'b10;

  always #5 clk = ~clk;

  fetch_src_pred dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
    .cur_addr(cur_addr), .next_addr(next_addr), .cur_src(cur_src),
    .next_dc_valid(next_dc_valid), .next_src(next_src)
  );

  // drive at the falling edge, sample 1 ns later, before the next rising edge
  task automatic step(input logic v, input logic [31:0] ca, input logic [31:0] na,
                      input logic [1:0] s, input logic dv, input logic [1:0] exp,
                      input string req);
    @(negedge clk);
    fetch_valid = v; cur_addr = ca; next_addr = na; cur_src = s; next_dc_valid = dv;
    #1;
    checks++;
    if (next_src !== exp) begin
      errors++;
      $display("FAIL %s: next_src=%b expected=%b (cur=%h next=%h)",
               req, next_src, exp, ca, na);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; fetch_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    // R1, R7: untrained crossing lookup picks the instruction cache
    step(1'b0, 32'h0000_0100, 32'h0000_0200, DC, 1'b1, IC, "R1");
    step(1'b0, 32'h0000_0040, 32'h0000_0080, LB, 1'b1, IC, "R1");
  endtask

  task automatic t_same_line();
    step(1'b1, 32'h0000_1000, 32'h0000_1004, LB, 1'b0, LB, "R3");
    step(1'b1, 32'h0000_100C, 32'h0000_1000, LB, 1'b1, LB, "R3 R2");
    step(1'b1, 32'h0000_1000, 32'h0000_1008, DC, 1'b1, DC, "R4");
    step(1'b1, 32'h0000_1000, 32'h0000_1008, DC, 1'b0, IC, "R5");
    step(1'b1, 32'h0000_1000, 32'h0000_1004, IC, 1'b1, IC, "R5");
  endtask

  task automatic t_training();
    // index 4, tag 0; next line tag 0
    step(1'b1, 32'h0000_0040, 32'h0000_0080, IC, 1'b0, IC, "R7");
    step(1'b0, 32'h0000_0040, 32'h0000_0080, IC, 1'b0, IC, "R8");   // write lag
    step(1'b0, 32'h0000_0040, 32'h0000_0080, IC, 1'b0, DC, "R6");
    step(1'b0, 32'h0000_0040, 32'h0000_0300, IC, 1'b0, DC, "R9");
    // alias: index 4 with tag 0x100 mismatches stored tag 0
    step(1'b0, 32'h0002_0040, 32'h0002_0080, IC, 1'b0, IC, "R7");
  endtask

  task automatic t_overwrite();
    // index 5, tag 0x80
    step(1'b1, 32'h0001_0050, 32'h0001_0090, IC, 1'b0, IC, "R7");
    step(1'b0, 32'h0000_0000, 32'h0000_0000, IC, 1'b0, IC, "R5");
    step(1'b0, 32'h0001_0050, 32'h0001_0090, IC, 1'b0, DC, "R6");
    // retrain index 5 with tag 0x180
    step(1'b1, 32'h0001_0050, 32'h0003_0000, IC, 1'b0, DC, "R8");
    step(1'b0, 32'h0001_0050, 32'h0001_0090, IC, 1'b0, DC, "R8");   // old entry still seen
    step(1'b0, 32'h0001_0050, 32'h0001_0090, IC, 1'b0, IC, "R8");
  endtask

  task automatic t_idle_no_write();
    // index 12, tag 0; would predict DC if written
    step(1'b0, 32'h0000_00C0, 32'h0000_0100, IC, 1'b0, IC, "R10");
    step(1'b0, 32'h0000_00C0, 32'h0000_0100, IC, 1'b0, IC, "R10");
    step(1'b0, 32'h0000_00C0, 32'h0000_0100, IC, 1'b0, IC, "R10");
  endtask

  task automatic t_reset_clears();
    do_reset();
    step(1'b0, 32'h0000_0040, 32'h0000_0080, IC, 1'b0, IC, "R1");
  endtask

  initial begin
    rst_n = 1'b0; fetch_valid = 1'b0; cur_addr = '0; next_addr = '0;
    cur_src = IC; next_dc_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_same_line();
    t_training();
    t_overwrite();
    t_idle_no_write();
    t_reset_clears();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule